// File: doc/BRIEF.md
# GPIO Interrupt Status Aggregator

This block gathers the per-pin interrupt and wake indications of a large GPIO array into a compact summary and drives a single shared interrupt line to the host. Pins are grouped in fours, and each group owns one summary bit. A group's bit is set while any of its four pins holds an unmasked interrupt or wake status. Software reads the summary from two 32-bit status words to find the pins that need service. It clears the per-pin status bits by writing 1 to them, then writes an end-of-interrupt bit that drops the shared line for at least one cycle, so that any pending work still left raises a fresh edge.

A master register also arms a settle window. While the window is armed, any write that updates a pin's debounce setting stops interrupt and wake status capture on every pin for a programmed number of reference-clock ticks. During that window every pin's enable bit reads back as 0. Events that arrive inside the window are dropped. Edge and level detection and glitch filtering happen upstream. This block receives already-qualified one-cycle event pulses for each pin.

Top module: `gpio_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, every pin register, the master register, both status words and `irq_out` read as 0.
- R2: A pin register at address p (0 to NUM_PINS-1) holds: bit 0 enable, bit 1 unmask, bit 2 interrupt status, bit 3 wake status, bits 7:4 debounce setting. An interrupt event pulse sets bit 2 only when the pin's enable is 1. A wake event pulse sets bit 3 regardless of enable. Writing 1 to bit 2 or bit 3 clears that status, and an event in the same cycle as the clear leaves the status set.
- R3: A pin is pending when (interrupt status OR wake status) AND unmask. Summary bit n is the OR of pending for pins 4n to 4n+3. Bits 0 to 31 read at address 0x1FD. Bits 32 to 45 read at address 0x1FE, bits 13:0, and bits 31:14 of that word read 0.
- R4: `irq_out` is registered. It is 1 exactly one cycle after any summary bit is 1, and 0 one cycle after all summary bits are 0.
- R5: The master register is at address 0x1FC: bits 11:0 are the window length L, bit 12 arms the window, and bit 13 is end-of-interrupt. A write with bit 13 = 1 stores bits 12:0 as usual and forces `irq_out` to 0 in the next cycle. In the cycle after that, `irq_out` again follows pending. Bit 13 always reads 0.
- R6: A pin write with bit 8 = 1 is a debounce update. If the window is armed and L is nonzero, it starts a window lasting L cycles of `tick_ref`. If the window is not armed, or L is 0, no window starts.
- R7: While a window is active, bit 0 of every pin register reads 0. The stored enable is kept, and it reads back unchanged once the window ends.
- R8: Interrupt and wake events that arrive while a window is active are discarded. They do not appear after the window ends.
- R9: A debounce update during an active window restarts the count at L.
- R10: Bits 7:4 of a pin register are written only when bit 8 of the write data is 1. Bit 8 reads 0, and writes with bit 8 = 0 leave the debounce setting unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 9 | Read address (combinational read) |
| rd_data | output | 32 | Read data for rd_addr |
| tick_ref | input | 1 | Reference-clock tick enable for the settle window |
| irq_evt | input | NUM_PINS | Per-pin qualified interrupt event pulses |
| wake_evt | input | NUM_PINS | Per-pin qualified wake event pulses |
| irq_out | output | 1 | Shared interrupt line to the host |

## Verification
A pin status bit stuck high or low shows up in the summary word on the same cycle it is read, and on `irq_out` one cycle later. A corrupted grouping shows as a summary bit set in the wrong position. A settle counter that loads or counts wrongly moves the point at which the enable bits read back as 1 by one or more `tick_ref` ticks. A window that leaks events leaves a stale status bit visible right after the window ends. A faulty end-of-interrupt path is visible in the single cycle after the write, when the line must be low and then high again.

// File: rtl/gpio_agg_pkg.sv
// Package: shared address map, field positions and write-field type for the
// GPIO interrupt status aggregator. Assumes a 9-bit word address space.
package gpio_agg_pkg;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 32;
    localparam int DBC_W  = 4;

    localparam logic [ADDR_W-1:0] ADDR_MASTER = 9'h1FC;
    localparam logic [ADDR_W-1:0] ADDR_STS_LO = 9'h1FD;
    localparam logic [ADDR_W-1:0] ADDR_STS_HI = 9'h1FE;

    // pin register fields
    localparam int PB_EN     = 0;
    localparam int PB_UNMASK = 1;
    localparam int PB_ISTS   = 2;
    localparam int PB_WSTS   = 3;
    localparam int PB_DBC    = 4;
    localparam int PB_DBCUPD = 8;

    // master register fields
    localparam int MB_ARM = 12;
    localparam int MB_EOI = 13;

    typedef struct packed {
        logic             en;
        logic             unmask;
        logic             clr_ists;
        logic             clr_wsts;
        logic             dbc_upd;
        logic [DBC_W-1:0] dbc;
    } pin_wr_t;
endpackage

// File: rtl/gpio_pin_bank.sv
// Module: gpio_pin_bank
// Holds the per-pin enable, unmask, status and debounce state for all pins.
// Assumes event pulses are already qualified upstream; block_i suppresses
// all status capture for the duration of a settle window.
module gpio_pin_bank
    import gpio_agg_pkg::*;
#(
    parameter int NUM_PINS = 184
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_sel_i,
    input  logic [ADDR_W-1:0]              wr_idx_i,
    input  pin_wr_t                        wr_i,
    input  logic                           block_i,
    input  logic [NUM_PINS-1:0]            irq_evt_i,
    input  logic [NUM_PINS-1:0]            wake_evt_i,
    output logic [NUM_PINS-1:0]            en_o,
    output logic [NUM_PINS-1:0]            unmask_o,
    output logic [NUM_PINS-1:0]            ists_o,
    output logic [NUM_PINS-1:0]            wsts_o,
    output logic [NUM_PINS-1:0][DBC_W-1:0] dbc_o
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic             sel;
        logic             en_q, unm_q, ists_q, wsts_q;
        logic [DBC_W-1:0] dbc_q;
        logic             ists_set, wsts_set, ists_clr, wsts_clr;

        // Decode this pin's write and the status set/clear conditions.
        always_comb begin
            sel      = wr_sel_i && (wr_idx_i == ADDR_W'(p));
            ists_set = irq_evt_i[p] && en_q && !block_i;
            wsts_set = wake_evt_i[p] && !block_i;
            ists_clr = sel && wr_i.clr_ists;
            wsts_clr = sel && wr_i.clr_wsts;
        end

        // Per-pin state registers; a set in the same cycle beats a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q   <= 1'b0;
                unm_q  <= 1'b0;
                ists_q <= 1'b0;
                wsts_q <= 1'b0;
                dbc_q  <= '0;
            end else begin
                if (sel) begin
                    en_q  <= wr_i.en;
                    unm_q <= wr_i.unmask;
                    if (wr_i.dbc_upd) dbc_q <= wr_i.dbc;
                end
                ists_q <= ists_set | (ists_q & ~ists_clr);
                wsts_q <= wsts_set | (wsts_q & ~wsts_clr);
            end
        end

        assign en_o[p]     = en_q;
        assign unmask_o[p] = unm_q;
        assign ists_o[p]   = ists_q;
        assign wsts_o[p]   = wsts_q;
        assign dbc_o[p]    = dbc_q;

        // R8: nothing is captured while the window blocks status generation
        a_r8_no_irq_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (block_i && !ists_q) |=> !ists_q);
        a_r8_no_wake_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (block_i && !wsts_q) |=> !wsts_q);
    end
endmodule

// File: rtl/gpio_settle_timer.sv
// Module: gpio_settle_timer
// Counts the status-suppression window in reference ticks. Assumes start_i
// is already qualified by the arm bit; a start reloads the count at any time.
module gpio_settle_timer #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             tick_i,
    output logic             block_o
);
    logic [LEN_W-1:0] cnt_q;

    // Load on start, otherwise count down once per reference tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= len_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - LEN_W'(1);
        end
    end

    // Window is active while the count is nonzero.
    assign block_o = (cnt_q != '0);

    // R9: a start always reloads the full length
    a_r9_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == $past(len_i)));
    // R6: an active window shrinks by exactly one per tick
    a_r6_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && tick_i && block_o) |=> (cnt_q == $past(cnt_q) - LEN_W'(1)));
    // R6: without ticks or starts the window length holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/gpio_irq_combiner.sv
// Module: gpio_irq_combiner
// Reduces per-pin pending bits into group summary bits and drives the shared
// interrupt line with a one-cycle forced drop on end-of-interrupt.
module gpio_irq_combiner #(
    parameter int NUM_PINS = 184,
    parameter int GRP_SIZE = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PINS-1:0]          pending_i,
    input  logic                         eoi_i,
    output logic [NUM_PINS/GRP_SIZE-1:0] summary_o,
    output logic                         irq_o
);
    localparam int NUM_GRP = NUM_PINS / GRP_SIZE;

    logic any_pending;
    logic irq_q;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        // One summary bit per group of consecutive pins.
        assign summary_o[g] = |pending_i[g*GRP_SIZE +: GRP_SIZE];
    end

    assign any_pending = |summary_o;

    // Register the line; end-of-interrupt forces one low cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= eoi_i ? 1'b0 : any_pending;
    end

    assign irq_o = irq_q;

    // R5: the line is low in the cycle after end-of-interrupt
    a_r5_eoi_drop: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_i |=> !irq_o);
    // R4: the line never rises without a summary bit one cycle earlier
    a_r4_line_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(any_pending));
    // R4: pending without an end-of-interrupt raises the line next cycle
    a_r4_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (any_pending && !eoi_i) |=> irq_o);
endmodule

// File: rtl/gpio_irq_agg.sv
// Module: gpio_irq_agg (top)
// Register decode and read mux for the GPIO interrupt status aggregator.
// Assumes NUM_PINS is a multiple of GRP_SIZE, at most 64 groups, LEN_W <= 12.
module gpio_irq_agg
    import gpio_agg_pkg::*;
#(
    parameter int NUM_PINS = 184,
    parameter int GRP_SIZE = 4,
    parameter int LEN_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [8:0]          wr_addr,
    input  logic [31:0]         wr_data,
    input  logic [8:0]          rd_addr,
    output logic [31:0]         rd_data,
    input  logic                tick_ref,
    input  logic [NUM_PINS-1:0] irq_evt,
    input  logic [NUM_PINS-1:0] wake_evt,
    output logic                irq_out
);
    localparam int NUM_GRP = NUM_PINS / GRP_SIZE;
    localparam int SUM_PAD = 64;

    logic                           pin_hit, mst_hit, eoi, dbc_touch, win_start;
    logic [LEN_W-1:0]               mst_len_q;
    logic                           mst_arm_q;
    logic                           block;
    pin_wr_t                        pin_wr;
    logic [NUM_PINS-1:0]            en_q, unm_q, ists_q, wsts_q, pending;
    logic [NUM_PINS-1:0][DBC_W-1:0] dbc_q;
    logic [NUM_GRP-1:0]             summary;
    logic [SUM_PAD-1:0]             sum_pad;
    logic                           rd_is_pin;

    // Decode writes into pin, master and end-of-interrupt strobes.
    always_comb begin
        pin_hit          = wr_en && (wr_addr < ADDR_W'(NUM_PINS));
        mst_hit          = wr_en && (wr_addr == ADDR_MASTER);
        eoi              = mst_hit && wr_data[MB_EOI];
        dbc_touch        = pin_hit && wr_data[PB_DBCUPD];
        win_start        = dbc_touch && mst_arm_q;
        pin_wr.en        = wr_data[PB_EN];
        pin_wr.unmask    = wr_data[PB_UNMASK];
        pin_wr.clr_ists  = wr_data[PB_ISTS];
        pin_wr.clr_wsts  = wr_data[PB_WSTS];
        pin_wr.dbc_upd   = wr_data[PB_DBCUPD];
        pin_wr.dbc       = wr_data[PB_DBC +: DBC_W];
    end

    // Master register: window length and arm bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_len_q <= '0;
            mst_arm_q <= 1'b0;
        end else if (mst_hit) begin
            mst_len_q <= wr_data[LEN_W-1:0];
            mst_arm_q <= wr_data[MB_ARM];
        end
    end

    gpio_settle_timer #(.LEN_W(LEN_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (win_start),
        .len_i   (mst_len_q),
        .tick_i  (tick_ref),
        .block_o (block)
    );

    gpio_pin_bank #(.NUM_PINS(NUM_PINS)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel_i   (pin_hit),
        .wr_idx_i   (wr_addr),
        .wr_i       (pin_wr),
        .block_i    (block),
        .irq_evt_i  (irq_evt),
        .wake_evt_i (wake_evt),
        .en_o       (en_q),
        .unmask_o   (unm_q),
        .ists_o     (ists_q),
        .wsts_o     (wsts_q),
        .dbc_o      (dbc_q)
    );

    // A pin is pending when any status is held and it is unmasked.
    assign pending = (ists_q | wsts_q) & unm_q;

    gpio_irq_combiner #(.NUM_PINS(NUM_PINS), .GRP_SIZE(GRP_SIZE)) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .eoi_i     (eoi),
        .summary_o (summary),
        .irq_o     (irq_out)
    );

    assign sum_pad   = SUM_PAD'(summary);
    assign rd_is_pin = (rd_addr < ADDR_W'(NUM_PINS));

    // Combinational read mux; enable reads 0 while the window is active.
    always_comb begin
        rd_data = '0;
        if (rd_is_pin) begin
            rd_data[PB_EN]            = en_q[rd_addr] && !block;
            rd_data[PB_UNMASK]        = unm_q[rd_addr];
            rd_data[PB_ISTS]          = ists_q[rd_addr];
            rd_data[PB_WSTS]          = wsts_q[rd_addr];
            rd_data[PB_DBC +: DBC_W]  = dbc_q[rd_addr];
        end else begin
            case (rd_addr)
                ADDR_MASTER: begin
                    rd_data[LEN_W-1:0] = mst_len_q;
                    rd_data[MB_ARM]    = mst_arm_q;
                end
                ADDR_STS_LO: rd_data = sum_pad[31:0];
                ADDR_STS_HI: rd_data = sum_pad[63:32];
                default:     rd_data = '0;
            endcase
        end
    end

    // R7: enable never reads 1 during a window
    a_r7_enable_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_is_pin && block) |-> !rd_data[PB_EN]);
    // R6: a disarmed, idle timer cannot open a window
    a_r6_no_window_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!mst_arm_q && !block) |=> !block);
    // R3: unused upper summary bits read 0
    a_r3_hi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_STS_HI) |-> (rd_data[31:NUM_GRP-32] == '0));
    // R5: end-of-interrupt bit never reads back
    a_r5_eoi_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_MASTER) |-> !rd_data[MB_EOI]);
endmodule

// File: tb/tb_gpio_irq_agg.sv
module tb_gpio_irq_agg;
    localparam int NP = 184;
    localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_IEV = 3'd2, K_WEV = 3'd3, K_LN = 3'd4;
    localparam int NV = 32;
    // kind, address, data (write data, expected read value or expected line)
    localparam logic [43:0] TBL [NV] = '{
        {K_WR, 9'd5, 32'h3},          {K_RD, 9'd5, 32'h3},
        {K_IEV, 9'd5, 32'h0},         {K_RD, 9'd5, 32'h7},
        {K_RD, 9'h1FD, 32'h2},        {K_LN, 9'd0, 32'h1},
        {K_WR, 9'd5, 32'h7},          {K_RD, 9'd5, 32'h3},
        {K_LN, 9'd0, 32'h0},          {K_WR, 9'd130, 32'h0},
        {K_IEV, 9'd130, 32'h0},       {K_RD, 9'd130, 32'h0},
        {K_WEV, 9'd130, 32'h0},       {K_RD, 9'd130, 32'h8},
        {K_RD, 9'h1FE, 32'h0},        {K_WR, 9'd130, 32'h2},
        {K_RD, 9'h1FE, 32'h1},        {K_WR, 9'd183, 32'h3},
        {K_IEV, 9'd183, 32'h0},       {K_RD, 9'h1FE, 32'h2001},
        {K_LN, 9'd0, 32'h1},          {K_WR, 9'd130, 32'hA},
        {K_WR, 9'd183, 32'h7},        {K_RD, 9'h1FE, 32'h0},
        {K_LN, 9'd0, 32'h0},          {K_WR, 9'd5, 32'h1F3},
        {K_RD, 9'd5, 32'hF3},         {K_WR, 9'd5, 32'h0A3},
        {K_RD, 9'd5, 32'hF3},         {K_WR, 9'h1FC, 32'h2005},
        {K_RD, 9'h1FC, 32'h5},        {K_RD, 9'h1FD, 32'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [8:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [8:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic          tick_ref = 1'b0;
    logic [NP-1:0] irq_evt = '0;
    logic [NP-1:0] wake_evt = '0;
    logic          irq_out;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_agg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tick_ref(tick_ref),
        .irq_evt(irq_evt), .wake_evt(wake_evt), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [8:0] a, input logic [31:0] exp);
        @(negedge clk); rd_addr = a; #1;
        check(req, rd_data, exp);
    endtask

    task automatic iev(input int p);
        @(negedge clk); irq_evt[p] = 1'b1;
        @(negedge clk); irq_evt[p] = 1'b0;
    endtask

    task automatic wev(input int p);
        @(negedge clk); wake_evt[p] = 1'b1;
        @(negedge clk); wake_evt[p] = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_ref = 1'b1;
            @(negedge clk); tick_ref = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd("R1 pin reg", 9'd5, 32'h0);
        rd("R1 master", 9'h1FC, 32'h0);
        rd("R1 status lo", 9'h1FD, 32'h0);
        rd("R1 status hi", 9'h1FE, 32'h0);
        check("R1 irq_out", {31'b0, irq_out}, 32'h0);

        // Table walk: R2 R3 R4 R10 pin fields, grouping and line
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  k;
            logic [8:0]  a;
            logic [31:0] d;
            k = TBL[i][43:41]; a = TBL[i][40:32]; d = TBL[i][31:0];
            case (k)
                K_WR:  wr(a, d);
                K_RD:  rd($sformatf("R2/R3/R10 table %0d", i), a, d);
                K_IEV: iev(int'(a));
                K_WEV: wev(int'(a));
                default: begin
                    @(negedge clk);
                    check($sformatf("R4 table %0d", i), {31'b0, irq_out}, d);
                end
            endcase
        end

        // R2: clear and event in the same cycle leaves status set
        @(negedge clk); wr_en = 1'b1; wr_addr = 9'd5; wr_data = 32'h7; irq_evt[5] = 1'b1;
        @(negedge clk); wr_en = 1'b0; irq_evt[5] = 1'b0;
        rd("R2 set beats clear", 9'd5, 32'hF7);
        wr(9'd5, 32'h7);
        rd("R2 cleared", 9'd5, 32'hF3);

        // R5: end-of-interrupt drops the line for one cycle
        iev(5);
        @(negedge clk);
        check("R4 line high", {31'b0, irq_out}, 32'h1);
        wr(9'h1FC, 32'h2003);
        check("R5 line low after eoi", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R5 line back", {31'b0, irq_out}, 32'h1);
        rd("R5 master readback", 9'h1FC, 32'h3);
        wr(9'd5, 32'h7);

        // R6 R7 R8: armed window of 3 ticks
        wr(9'h1FC, 32'h1003);
        wr(9'd5, 32'h153);
        rd("R7 enable hidden pin5", 9'd5, 32'h52);
        rd("R7 enable hidden pin183", 9'd183, 32'h2);
        iev(5);
        wev(183);
        tick(2);
        rd("R6 still blocked", 9'd5, 32'h52);
        tick(1);
        rd("R7 enable restored", 9'd5, 32'h53);
        rd("R8 wake dropped", 9'd183, 32'h3);
        rd("R8 summary empty", 9'h1FE, 32'h0);
        @(negedge clk);
        check("R8 line quiet", {31'b0, irq_out}, 32'h0);

        // R9: restart during window
        wr(9'd5, 32'h153);
        tick(2);
        wr(9'd5, 32'h153);
        tick(2);
        rd("R9 restarted", 9'd5, 32'h52);
        tick(1);
        rd("R9 ends", 9'd5, 32'h53);

        // R6: zero length and disarmed open no window
        wr(9'h1FC, 32'h1000);
        wr(9'd5, 32'h163);
        rd("R6 zero length", 9'd5, 32'h63);
        wr(9'h1FC, 32'h0005);
        wr(9'd5, 32'h173);
        rd("R6 disarmed", 9'd5, 32'h73);

        done = 1'b1;
        finish_run();
    end
endmodule